// File: doc/BRIEF.md
# Supply-Aware Operating Mode Controller

This block holds the operating mode of a multi-channel output driver. It has six modes: idle, init, active, configuration-memory (OTP) access, fail-safe and fail-off. Each clock it weighs supply comparator flags, decoded bus command strobes, watchdog and pin warnings, self-test and OTP status and fault flags. It then picks the next mode by a fixed priority. The comparators, the bus decoder and the OTP memory sit outside; they reach the block as single-bit flags that are already synchronous to `clk`.

The mode is registered and appears on a one-hot output with these bit positions: bit0 idle, bit1 init, bit2 active, bit3 OTP, bit4 fail-safe, bit5 fail-off. A one-cycle pulse marks every mode change. Three outputs are decoded from the mode: output-stage enable, diagnosis enable and ADC-valid.

Top module: `supply_mode_ctrl`

## Requirements
- R1: Asynchronous reset (`rst_n` low) puts the block in idle. From any mode, `vs_uv_fall` high moves it to idle at the next edge. Idle moves to init only when `vs_ok_rise` is high and `vs_uv_fall` is low; otherwise it stays in idle.
- R2: Active and fail-safe move to init on `cmd_init` or once the sync-break counter has reached BRK_COUNT (default 6).
- R3: The sync-break counter adds one per `cmd_sync_brk` strobe and saturates at BRK_COUNT. It clears on any other bus command (init, fail-safe, duty update, OTP enter, OTP exit), on every mode change and while in idle.
- R4: Init moves to active on `cmd_dc_upd` or `gp_level` high, but only if all of these hold: `bist_ok`, (`otp_locked` or `otp_emu_ok`), `vdd_ok_rise` and `vs_ok_opmin`.
- R5: Any of the following moves init, active, OTP or fail-safe to fail-off: `int_fault`, `vdd_uv_fall`, `err_pin_low`, or `load_fault` when LOAD_FAULT_OFF is 1. Fail-off ignores every command and leaves only through R1.
- R6: Active moves to fail-safe on `wdt_expired`, on `cmd_fsafe`, or when `wdt_off` and `gp_warn` are both high.
- R7: Init moves to fail-safe on `wdt_expired` or `cmd_fsafe`, but only while `bist_ok` is high.
- R8: Fail-safe returns to active on `cmd_dc_upd` or on a high-to-low change of `gp_warn` between two samples. A `gp_warn` that stays high keeps the block in fail-safe.
- R9: `cmd_otp_enter` moves init to OTP, and `cmd_otp_exit` moves OTP back to init. `out_en` stays low in OTP.
- R10: `out_en` is high only in active or fail-safe while `vs_uv_fall` is low. `diag_en` is high only in active, fail-safe or OTP while `vs_uv_fall` is low. `adc_valid` is high exactly in active, fail-safe and OTP.
- R11: Simultaneous conditions resolve in this order: supply undervoltage, then fail-off faults, then init requests, then fail-safe requests, then the normal transitions (R4, R8, R9).
- R12: `mode_oh` always has exactly one bit set, using the bit positions above. `mode_chg` is high for exactly the cycle in which a new mode first shows on `mode_oh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vs_uv_fall | input | 1 | Main supply below its falling undervoltage threshold |
| vs_ok_rise | input | 1 | Main supply above its rising undervoltage threshold |
| vs_ok_opmin | input | 1 | Main supply above its minimum operating level |
| vdd_ok_rise | input | 1 | Bus bias supply above its rising threshold |
| vdd_uv_fall | input | 1 | Bus bias supply at or below its falling threshold |
| err_pin_low | input | 1 | Error-pin voltage below its threshold |
| int_fault | input | 1 | Internal fault |
| load_fault | input | 1 | Load fault, used when enabled by parameter |
| cmd_init | input | 1 | Enter-init command strobe |
| cmd_fsafe | input | 1 | Enter-fail-safe command strobe |
| cmd_dc_upd | input | 1 | Duty-cycle update command strobe |
| cmd_sync_brk | input | 1 | Sync-break event strobe |
| cmd_otp_enter | input | 1 | Enter OTP mode strobe |
| cmd_otp_exit | input | 1 | Leave OTP mode strobe |
| wdt_expired | input | 1 | Watchdog timeout |
| wdt_off | input | 1 | Watchdog disabled |
| gp_level | input | 1 | General-purpose input level |
| gp_warn | input | 1 | General-purpose input warning |
| bist_ok | input | 1 | Built-in self-tests passed |
| otp_locked | input | 1 | OTP locked |
| otp_emu_ok | input | 1 | Valid OTP emulation present |
| mode_oh | output | 6 | One-hot mode |
| out_en | output | 1 | Output-stage enable |
| diag_en | output | 1 | Diagnosis enable |
| adc_valid | output | 1 | ADC readings valid |
| mode_chg | output | 1 | One-cycle mode-change pulse |

## Verification
The assertions check on every cycle the properties that do not depend on history: the drop to idle on supply loss, idle holding until the rising threshold, the forced move to fail-off, fail-off holding, the one-hot mode, the pairing of mode changes with the pulse, counter saturation and no output drive in OTP. Other behaviour can only be shown by scenarios. These are the gating of init-to-active by every qualifier, the warning falling edge that ends fail-safe, a run of sync-breaks broken by another command, and the priority outcome when several requests land in the same cycle. The bench's reference model follows them on every clock.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [2:0] {
      M_IDLE   = 3'd0,
      M_INIT   = 3'd1,
      M_ACTIVE = 3'd2,
      M_OTP    = 3'd3,
      M_FSAFE  = 3'd4,
      M_FOFF   = 3'd5
   } smc_mode_e;

   localparam int unsigned SMC_NUM_MODES = 6;

   typedef struct packed {
      logic supply_lost;
      logic supply_back;
      logic fault;
      logic init_req;
      logic fs_req_act;
      logic fs_req_init;
      logic act_ok_init;
      logic act_ok_fs;
      logic otp_enter;
      logic otp_exit;
   } smc_cond_t;

endpackage

// File: rtl/smc_brk_cnt.sv
module smc_brk_cnt #(
   parameter  int unsigned LIMIT = 6,
   localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic clr,
   output logic full
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("smc_brk_cnt: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (strobe && (cnt != CW'(LIMIT))) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CW'(LIMIT));

   AST_BRK_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT)); // R3
   AST_BRK_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full); // R3

endmodule

// File: rtl/smc_arbiter.sv
module smc_arbiter
   import smc_pkg::*;
(
   input  smc_mode_e cur,
   input  smc_cond_t c,
   output smc_mode_e nxt
);

   always_comb begin
      nxt = cur;
      if (c.supply_lost) begin
         nxt = M_IDLE;
      end else begin
         unique case (cur)
            M_IDLE: begin
               if (c.supply_back) nxt = M_INIT;
            end
            M_FOFF: begin
               nxt = M_FOFF;
            end
            M_INIT: begin
               if (c.fault)             nxt = M_FOFF;
               else if (c.init_req)     nxt = M_INIT;
               else if (c.fs_req_init)  nxt = M_FSAFE;
               else if (c.act_ok_init)  nxt = M_ACTIVE;
               else if (c.otp_enter)    nxt = M_OTP;
            end
            M_ACTIVE: begin
               if (c.fault)             nxt = M_FOFF;
               else if (c.init_req)     nxt = M_INIT;
               else if (c.fs_req_act)   nxt = M_FSAFE;
            end
            M_FSAFE: begin
               if (c.fault)             nxt = M_FOFF;
               else if (c.init_req)     nxt = M_INIT;
               else if (c.act_ok_fs)    nxt = M_ACTIVE;
            end
            M_OTP: begin
               if (c.fault)             nxt = M_FOFF;
               else if (c.otp_exit)     nxt = M_INIT;
            end
            default: nxt = M_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/smc_out_dec.sv
module smc_out_dec
   import smc_pkg::*;
#(
   parameter int unsigned NM          = SMC_NUM_MODES,
   parameter bit          DIAG_IN_OTP = 1'b1
) (
   input  smc_mode_e        mode,
   input  logic             supply_lost,
   output logic [NM-1:0]    mode_oh,
   output logic             out_en,
   output logic             diag_en,
   output logic             adc_valid
);

   generate
      if (NM != SMC_NUM_MODES) begin : g_bad_nm
         $error("smc_out_dec: NM must equal the number of modes");
      end
   endgenerate

   for (genvar i = 0; i < NM; i++) begin : g_oh
      assign mode_oh[i] = (mode == smc_mode_e'(3'(i)));
   end

   logic drive_mode;
   logic diag_mode;

   assign drive_mode = (mode == M_ACTIVE) || (mode == M_FSAFE);

   generate
      if (DIAG_IN_OTP) begin : g_diag_otp
         assign diag_mode = drive_mode || (mode == M_OTP);
      end else begin : g_diag_drv
         assign diag_mode = drive_mode;
      end
   endgenerate

   assign out_en    = drive_mode && !supply_lost;
   assign diag_en   = diag_mode && !supply_lost;
   assign adc_valid = drive_mode || (mode == M_OTP);

endmodule

// File: rtl/supply_mode_ctrl.sv
module supply_mode_ctrl
   import smc_pkg::*;
#(
   parameter int unsigned BRK_COUNT      = 6,
   parameter bit          LOAD_FAULT_OFF = 1'b1,
   parameter bit          DIAG_IN_OTP    = 1'b1,
   localparam int unsigned NM            = SMC_NUM_MODES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vs_uv_fall,
   input  logic          vs_ok_rise,
   input  logic          vs_ok_opmin,
   input  logic          vdd_ok_rise,
   input  logic          vdd_uv_fall,
   input  logic          err_pin_low,
   input  logic          int_fault,
   input  logic          load_fault,
   input  logic          cmd_init,
   input  logic          cmd_fsafe,
   input  logic          cmd_dc_upd,
   input  logic          cmd_sync_brk,
   input  logic          cmd_otp_enter,
   input  logic          cmd_otp_exit,
   input  logic          wdt_expired,
   input  logic          wdt_off,
   input  logic          gp_level,
   input  logic          gp_warn,
   input  logic          bist_ok,
   input  logic          otp_locked,
   input  logic          otp_emu_ok,
   output logic [NM-1:0] mode_oh,
   output logic          out_en,
   output logic          diag_en,
   output logic          adc_valid,
   output logic          mode_chg
);

   smc_mode_e mode, nxt;
   smc_cond_t cond;
   logic      warn_q;
   logic      brk_full;
   logic      brk_clr;
   logic      other_cmd;
   logic      load_hit;

   generate
      if (LOAD_FAULT_OFF) begin : g_load_on
         assign load_hit = load_fault;
      end else begin : g_load_off
         assign load_hit = 1'b0;
      end
   endgenerate

   assign other_cmd = cmd_init | cmd_fsafe | cmd_dc_upd | cmd_otp_enter | cmd_otp_exit;

   always_comb begin
      cond             = '0;
      cond.supply_lost = vs_uv_fall;
      cond.supply_back = vs_ok_rise;
      cond.fault       = int_fault | vdd_uv_fall | err_pin_low | load_hit;
      cond.init_req    = cmd_init | brk_full;
      cond.fs_req_act  = wdt_expired | cmd_fsafe | (wdt_off & gp_warn);
      cond.fs_req_init = (wdt_expired | cmd_fsafe) & bist_ok;
      cond.act_ok_init = (cmd_dc_upd | gp_level) & bist_ok & (otp_locked | otp_emu_ok)
                         & vdd_ok_rise & vs_ok_opmin;
      cond.act_ok_fs   = cmd_dc_upd | (warn_q & ~gp_warn);
      cond.otp_enter   = cmd_otp_enter;
      cond.otp_exit    = cmd_otp_exit;
   end

   smc_arbiter u_arb (
      .cur (mode),
      .c   (cond),
      .nxt (nxt)
   );

   assign brk_clr = other_cmd | (nxt != mode) | (mode == M_IDLE);

   smc_brk_cnt #(.LIMIT(BRK_COUNT)) u_brk (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cmd_sync_brk),
      .clr    (brk_clr),
      .full   (brk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= M_IDLE;
         mode_chg <= 1'b0;
         warn_q   <= 1'b0;
      end else begin
         mode     <= nxt;
         mode_chg <= (nxt != mode);
         warn_q   <= gp_warn;
      end
   end

   smc_out_dec #(.NM(NM), .DIAG_IN_OTP(DIAG_IN_OTP)) u_dec (
      .mode        (mode),
      .supply_lost (vs_uv_fall),
      .mode_oh     (mode_oh),
      .out_en      (out_en),
      .diag_en     (diag_en),
      .adc_valid   (adc_valid)
   );

   AST_SUPPLY_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      vs_uv_fall |=> (mode == M_IDLE)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == M_IDLE) && !vs_ok_rise) |=> (mode == M_IDLE)); // R1
   AST_FAULT_FOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!vs_uv_fall && int_fault && (mode != M_IDLE)) |=> (mode == M_FOFF)); // R5
   AST_FOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == M_FOFF) && !vs_uv_fall) |=> (mode == M_FOFF)); // R5
   AST_OTP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_oh[3] |-> !out_en); // R9
   AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1); // R12
   AST_CHG_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> mode_chg); // R12
   AST_CHG_ONLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> (mode != $past(mode))); // R12

endmodule

// File: tb/supply_mode_ctrl_tb_top.sv
module supply_mode_ctrl_tb_top;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic vs_uv_fall, vs_ok_rise, vs_ok_opmin, vdd_ok_rise, vdd_uv_fall, err_pin_low;
   logic int_fault, load_fault;
   logic cmd_init, cmd_fsafe, cmd_dc_upd, cmd_sync_brk, cmd_otp_enter, cmd_otp_exit;
   logic wdt_expired, wdt_off, gp_level, gp_warn, bist_ok, otp_locked, otp_emu_ok;
   logic [5:0] mode_oh;
   logic out_en, diag_en, adc_valid, mode_chg;

   supply_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .vs_uv_fall(vs_uv_fall), .vs_ok_rise(vs_ok_rise), .vs_ok_opmin(vs_ok_opmin),
      .vdd_ok_rise(vdd_ok_rise), .vdd_uv_fall(vdd_uv_fall), .err_pin_low(err_pin_low),
      .int_fault(int_fault), .load_fault(load_fault),
      .cmd_init(cmd_init), .cmd_fsafe(cmd_fsafe), .cmd_dc_upd(cmd_dc_upd),
      .cmd_sync_brk(cmd_sync_brk), .cmd_otp_enter(cmd_otp_enter), .cmd_otp_exit(cmd_otp_exit),
      .wdt_expired(wdt_expired), .wdt_off(wdt_off), .gp_level(gp_level), .gp_warn(gp_warn),
      .bist_ok(bist_ok), .otp_locked(otp_locked), .otp_emu_ok(otp_emu_ok),
      .mode_oh(mode_oh), .out_en(out_en), .diag_en(diag_en),
      .adc_valid(adc_valid), .mode_chg(mode_chg)
   );

   // mode numbers: 0 idle, 1 init, 2 active, 3 otp, 4 fail-safe, 5 fail-off
   int checks = 0;
   int errors = 0;
   string tag = "R1";
   int ref_mode = 0;
   int ref_brk = 0;
   bit ref_chg = 0;
   bit ref_warn_prev = 0;
   int cyc = 0;

   // Behavioural reference model, evaluated on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_mode = 0; ref_brk = 0; ref_chg = 0; ref_warn_prev = 0;
      end else begin
         int nm;
         bit flt, any_cmd, go_init;
         nm = ref_mode;
         flt = int_fault || vdd_uv_fall || err_pin_low || load_fault;
         any_cmd = cmd_init || cmd_fsafe || cmd_dc_upd || cmd_otp_enter || cmd_otp_exit;
         go_init = cmd_init || (ref_brk >= 6);
         if (vs_uv_fall) nm = 0;
         else if (ref_mode == 0) begin
            if (vs_ok_rise) nm = 1;
         end
         else if (ref_mode == 5) nm = 5;
         else if (flt) nm = 5;
         else if (ref_mode == 2) begin
            if (go_init) nm = 1;
            else if (wdt_expired || cmd_fsafe || (wdt_off && gp_warn)) nm = 4;
         end
         else if (ref_mode == 4) begin
            if (go_init) nm = 1;
            else if (cmd_dc_upd || (ref_warn_prev && !gp_warn)) nm = 2;
         end
         else if (ref_mode == 1) begin
            if (go_init) nm = 1;
            else if ((wdt_expired || cmd_fsafe) && bist_ok) nm = 4;
            else if ((cmd_dc_upd || gp_level) && bist_ok && (otp_locked || otp_emu_ok)
                     && vdd_ok_rise && vs_ok_opmin) nm = 2;
            else if (cmd_otp_enter) nm = 3;
         end
         else if (ref_mode == 3) begin
            if (cmd_otp_exit) nm = 1;
         end
         if (ref_mode == 0 || nm != ref_mode || any_cmd) ref_brk = 0;
         else if (cmd_sync_brk && ref_brk < 6) ref_brk = ref_brk + 1;
         ref_chg = (nm != ref_mode);
         ref_mode = nm;
         ref_warn_prev = gp_warn;
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what,
                      input string r);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
      end
   endtask

   // Full comparison against the model on every falling edge
   always @(negedge clk) begin
      bit drv, dg, av;
      drv = (ref_mode == 2 || ref_mode == 4) && !vs_uv_fall;
      dg  = (ref_mode == 2 || ref_mode == 4 || ref_mode == 3) && !vs_uv_fall;
      av  = (ref_mode == 2 || ref_mode == 4 || ref_mode == 3);
      chk({2'b0, mode_oh}, 8'(1 << ref_mode), "mode_oh", tag);
      chk({7'b0, out_en}, {7'b0, drv}, "out_en", tag);
      chk({7'b0, diag_en}, {7'b0, dg}, "diag_en", tag);
      chk({7'b0, adc_valid}, {7'b0, av}, "adc_valid", tag);
      chk({7'b0, mode_chg}, {7'b0, ref_chg}, "mode_chg", tag);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R12 watchdog actual=%0d expected<=20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // Independent expectation of the mode, written from the requirements
   task automatic expect_mode(input int m, input string r);
      @(negedge clk);
      chk({2'b0, mode_oh}, 8'(1 << m), "scenario mode", r);
   endtask

   task automatic expect_bit(input logic act, input logic exp, input string what,
                             input string r);
      chk({7'b0, act}, {7'b0, exp}, what, r);
   endtask

   initial begin
      rst_n = 0;
      vs_uv_fall = 1; vs_ok_rise = 0; vs_ok_opmin = 0; vdd_ok_rise = 1; vdd_uv_fall = 0;
      err_pin_low = 0; int_fault = 0; load_fault = 0;
      cmd_init = 0; cmd_fsafe = 0; cmd_dc_upd = 0; cmd_sync_brk = 0;
      cmd_otp_enter = 0; cmd_otp_exit = 0;
      wdt_expired = 0; wdt_off = 0; gp_level = 0; gp_warn = 0;
      bist_ok = 1; otp_locked = 1; otp_emu_ok = 0;
      tag = "R1";
      repeat (3) step();
      expect_mode(0, "R1");
      expect_bit(out_en, 0, "reset out_en", "R10");
      step(); rst_n = 1;
      repeat (3) step();
      expect_mode(0, "R1");
      // hysteresis: falling flag gone, rising flag not yet set
      vs_uv_fall = 0;
      repeat (3) step();
      expect_mode(0, "R1");
      vs_ok_rise = 1;
      step(); expect_mode(1, "R1");
      expect_bit(mode_chg, 1, "change pulse", "R12");
      step(); expect_bit(mode_chg, 0, "pulse length", "R12");

      tag = "R4";
      gp_level = 1; bist_ok = 0;
      repeat (2) step();
      expect_mode(1, "R4");
      bist_ok = 1;
      repeat (2) step();
      expect_mode(1, "R4");
      vs_ok_opmin = 1;
      step(); expect_mode(2, "R4");
      gp_level = 0;
      expect_bit(out_en, 1, "active out_en", "R10");
      expect_bit(adc_valid, 1, "active adc_valid", "R10");

      tag = "R6";
      wdt_off = 1; gp_warn = 1;
      step(); expect_mode(4, "R6");
      tag = "R8";
      step(); expect_mode(4, "R8");
      gp_warn = 0;
      step(); expect_mode(2, "R8");
      wdt_off = 0;

      tag = "R6";
      cmd_fsafe = 1; step(); cmd_fsafe = 0; expect_mode(4, "R6");
      tag = "R8";
      cmd_dc_upd = 1; step(); cmd_dc_upd = 0; expect_mode(2, "R8");
      tag = "R6";
      wdt_expired = 1; step(); wdt_expired = 0; expect_mode(4, "R6");
      cmd_dc_upd = 1; step(); cmd_dc_upd = 0; expect_mode(2, "R8");

      tag = "R3";
      cmd_sync_brk = 1; repeat (5) step(); cmd_sync_brk = 0;
      cmd_dc_upd = 1; step(); cmd_dc_upd = 0;
      cmd_sync_brk = 1; repeat (5) step(); cmd_sync_brk = 0;
      step(); expect_mode(2, "R3");
      tag = "R2";
      cmd_sync_brk = 1; step(); cmd_sync_brk = 0;
      step(); expect_mode(1, "R2");

      tag = "R9";
      cmd_otp_enter = 1; step(); cmd_otp_enter = 0; expect_mode(3, "R9");
      expect_bit(out_en, 0, "otp out_en", "R9");
      expect_bit(adc_valid, 1, "otp adc_valid", "R10");
      cmd_otp_exit = 1; step(); cmd_otp_exit = 0; expect_mode(1, "R9");

      tag = "R7";
      bist_ok = 0;
      wdt_expired = 1; step(); wdt_expired = 0; expect_mode(1, "R7");
      bist_ok = 1;
      cmd_fsafe = 1; step(); cmd_fsafe = 0; expect_mode(4, "R7");

      tag = "R2";
      cmd_init = 1; step(); cmd_init = 0; expect_mode(1, "R2");
      gp_level = 1; step(); gp_level = 0; expect_mode(2, "R4");

      tag = "R11";
      cmd_init = 1; cmd_fsafe = 1; step(); cmd_init = 0; cmd_fsafe = 0;
      expect_mode(1, "R11");
      gp_level = 1; step(); gp_level = 0; expect_mode(2, "R11");
      int_fault = 1; cmd_init = 1; step(); cmd_init = 0; expect_mode(5, "R11");
      int_fault = 0;
      tag = "R5";
      cmd_init = 1; step(); cmd_init = 0; expect_mode(5, "R5");
      gp_level = 1; step(); gp_level = 0; expect_mode(5, "R5");
      tag = "R11";
      vs_uv_fall = 1; int_fault = 1; step(); expect_mode(0, "R11");
      expect_bit(diag_en, 0, "idle diag_en", "R10");
      int_fault = 0; vs_uv_fall = 0;
      tag = "R1";
      step(); expect_mode(1, "R1");

      tag = "R5";
      load_fault = 1; step(); load_fault = 0; expect_mode(5, "R5");
      vs_uv_fall = 1; step(); vs_uv_fall = 0; expect_mode(0, "R1");
      step(); expect_mode(1, "R1");
      gp_level = 1; step(); gp_level = 0; expect_mode(2, "R4");
      err_pin_low = 1; step(); err_pin_low = 0; expect_mode(5, "R5");
      vs_uv_fall = 1; step(); vs_uv_fall = 0; step();
      gp_level = 1; step(); gp_level = 0; expect_mode(2, "R4");
      vdd_uv_fall = 1; step(); vdd_uv_fall = 0; expect_mode(5, "R5");
      vs_uv_fall = 1; step(); vs_uv_fall = 0; step();
      otp_locked = 0; otp_emu_ok = 1;
      gp_level = 1; step(); gp_level = 0; expect_mode(2, "R4");

      tag = "R10";
      vs_uv_fall = 1;
      @(negedge clk);
      expect_bit(out_en, 0, "uv out_en", "R10");
      expect_bit(diag_en, 0, "uv diag_en", "R10");
      step(); expect_mode(0, "R1");
      vs_uv_fall = 0;
      repeat (2) step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule